// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Driver

This block takes a serial bit stream, assembles it in a shift register clocked by a dedicated shift clock, and copies the assembled word into a holding register on the rising edge of a separate latch clock. The holding register drives a set of on/off enable bits for low-side output stages. A 1 turns a stage on so that it sinks current, and a 0 turns it off. An active-low output enable blanks every drive bit without disturbing the held word. An active-low clear empties both registers at once.

A serial cascade output presents the last shift stage so that several blocks can be chained into a longer register. The cascade output is retimed on the falling edge of the shift clock. This gives the next block in the chain half a clock period of hold margin when clock skew is present. The clear takes effect asynchronously. Its release is synchronized separately into each clock domain, so a clear that is released close to a clock edge cannot leave a partial shift or a partial load.

Top module: `sipo_latch_driver`

## Requirements
- R1: On each rising edge of `sclk`, `ser_in` enters shift stage 0 and every stage k takes the value of stage k-1. Stage 0 maps to `drive[0]`, so after eight shifts the first bit entered appears on `drive[7]`.
- R2: On each rising edge of `lclk`, the holding register loads all shift stages in parallel. Shift edges alone leave `drive` unchanged.
- R3: While `clr_n` is low, the shift register, the holding register and `cascade_out` are all 0, taking effect at once without any clock edge.
- R4: After `clr_n` rises, the first two rising edges of `sclk` neither shift nor load data, and the first two rising edges of `lclk` do not load data (parameter SYNC_STAGES = 2).
- R5: While `oe_n` is high, every `drive` bit is 0, whatever the holding register contains.
- R6: While `oe_n` is low, `drive` equals the holding register. Bit value 1 means the stage is on.
- R7: `cascade_out` takes the value of the last shift stage on the falling edge of `sclk`. It keeps its previous value while `sclk` is high.
- R8: When `sclk` and `lclk` are tied together, the holding register captures the shift contents from before that same edge's shift.
- R9: Two blocks chained from `cascade_out` to `ser_in`, with shared clocks, behave as one 16-bit register. The downstream block holds the first eight bits entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Shift clock. Rising edge shifts; falling edge updates the cascade output |
| lclk | input | 1 | Latch clock. Rising edge loads the holding register |
| clr_n | input | 1 | Asynchronous active-low clear of all registers |
| oe_n | input | 1 | Active-low output enable |
| ser_in | input | 1 | Serial data in |
| drive | output | WIDTH | Drive enables for the output stages, 1 = on |
| cascade_out | output | 1 | Serial data out for chaining, retimed on the falling edge of `sclk` |

## Verification
A shift result is visible in the stages immediately after the rising `sclk` edge. It reaches `drive` only after the next rising `lclk` edge, so the bench samples `drive` a few nanoseconds after that latch edge and never between edges. `cascade_out` is due at the falling edge that follows a shift. The bench samples it once in the high phase, where the old value must persist, and once after the fall. Clear and output-enable act combinationally, so their checks are taken 1 ns after the input changes. After each clear release, the bench spends exactly two edges of each clock before it expects any data movement.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int unsigned DEF_WIDTH       = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/clr_release_sync.sv
// Clear asserts asynchronously; release is retimed into one clock domain.
module clr_release_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic rst
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst = ~pipe_q[STAGES-1];
endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic [WIDTH-1:0] stage_q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) stage_q <= '0;
    else     stage_q <= {stage_q[WIDTH-2:0], din};
  end

  // R1: every stage advances by one per shift edge
  assert_shift_advance_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (stage_q[WIDTH-1:1] == $past(stage_q[WIDTH-2:0]))
                    && (stage_q[0] == $past(din)));
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/sipo_latch_driver.sv
module sipo_latch_driver #(
  parameter int unsigned WIDTH       = sipo_pkg::DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = sipo_pkg::DEF_SYNC_STAGES
) (
  input  logic             sclk,
  input  logic             lclk,
  input  logic             clr_n,
  input  logic             oe_n,
  input  logic             ser_in,
  output logic [WIDTH-1:0] drive,
  output logic             cascade_out
);
  localparam int unsigned LAST = WIDTH - 1;

  logic             rst_s;
  logic             rst_l;
  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] hold_q;
  logic             casc_q;

  clr_release_sync #(.STAGES(SYNC_STAGES)) u_sync_s (
    .clk(sclk), .clr_n(clr_n), .rst(rst_s)
  );

  clr_release_sync #(.STAGES(SYNC_STAGES)) u_sync_l (
    .clk(lclk), .clr_n(clr_n), .rst(rst_l)
  );

  shift_chain #(.WIDTH(WIDTH)) u_shift (
    .clk(sclk), .rst(rst_s), .din(ser_in), .stage_q(shift_q)
  );

  hold_reg #(.WIDTH(WIDTH)) u_hold (
    .clk(lclk), .rst(rst_l), .d(shift_q), .q(hold_q)
  );

  // Cascade retimed on the falling shift edge for downstream hold margin
  always_ff @(negedge sclk or posedge rst_s) begin
    if (rst_s) casc_q <= 1'b0;
    else       casc_q <= shift_q[LAST];
  end

  assign cascade_out = casc_q;
  assign drive       = oe_n ? '0 : hold_q;

  // R2: held word is the shift word seen at the previous latch edge
  assert_parallel_load_R2: assert property (@(posedge lclk) disable iff (rst_l)
    !$past(rst_l) |-> hold_q == $past(shift_q));

  // R7: cascade carries last stage as sampled at the previous falling edge
  assert_cascade_fall_R7: assert property (@(negedge sclk) disable iff (rst_s)
    !$past(rst_s) |-> cascade_out == $past(shift_q[LAST]));

  // R3: a held clear leaves no active drive and a quiet cascade
  assert_clear_quiet_R3: assert property (@(posedge sclk) disable iff (oe_n)
    !clr_n |-> (drive == '0) && !cascade_out);

  // R5: disabled outputs never drive
  assert_blank_when_off_R5: assert property (@(posedge lclk) disable iff (!clr_n)
    oe_n |-> drive == '0);
endmodule

// File: tb/test_sipo_latch_driver.sv
module test_sipo_latch_driver;
  logic clk = 1'b0;
  logic sclk = 1'b0, lclk = 1'b0, clr_n = 1'b1, oe_n = 1'b0, ser_in = 1'b0;
  logic [7:0] d0, d1;
  logic c0, c1;
  int checks = 0, fails = 0;
  logic done = 1'b0;
  logic [15:0] m = '0;   // chained shift model, bits [7:0] first block
  logic [15:0] st = '0;  // chained holding model

  always #5 clk = ~clk;

  sipo_latch_driver i_sipo_latch_driver (
    .sclk(sclk), .lclk(lclk), .clr_n(clr_n), .oe_n(oe_n), .ser_in(ser_in),
    .drive(d0), .cascade_out(c0));

  sipo_latch_driver i_sipo_latch_driver_nxt (
    .sclk(sclk), .lclk(lclk), .clr_n(clr_n), .oe_n(oe_n), .ser_in(c0),
    .drive(d1), .cascade_out(c1));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b; #2 sclk = 1'b1; m = {m[14:0], b};
    #5 sclk = 1'b0; #3;
  endtask

  task automatic latch;
    #2 lclk = 1'b1; st = m; #5 lclk = 1'b0; #3;
  endtask

  task automatic release_clear;
    clr_n = 1'b1; m = '0; st = '0; #2;
    for (int k = 0; k < 2; k++) begin
      ser_in = 1'b1; #2 sclk = 1'b1; lclk = 1'b1; #5 sclk = 1'b0; lclk = 1'b0; #3;
    end
  endtask

  task automatic t_reset;
    oe_n = 1'b0;
    #1 clr_n = 1'b0; #2;
    chk("R3 reset drive0", {8'h0, d0}, 16'h0);
    chk("R3 reset drive1", {8'h0, d1}, 16'h0);
    chk("R3 reset cascade", {14'h0, c1, c0}, 16'h0);
  endtask

  task automatic t_release;
    release_clear();
    latch();
    chk("R4 sync edges ignored", {d1, d0}, 16'h0000);
  endtask

  task automatic t_shift_load(input logic [7:0] v);
    for (int k = 7; k >= 0; k--) shift_bit(v[k]);
    chk("R2 no change before latch", {d1, d0}, st);
    latch();
    chk("R1 byte order drive0", {8'h0, d0}, {8'h0, v});
    chk("R1 first bit on drive7", {15'h0, d0[7]}, {15'h0, v[7]});
    chk("R9 downstream drive1", {8'h0, d1}, {8'h0, st[15:8]});
  endtask

  task automatic t_enable;
    oe_n = 1'b1; #1;
    chk("R5 blanked", {d1, d0}, 16'h0);
    oe_n = 1'b0; #1;
    chk("R6 pass through", {d1, d0}, st);
  endtask

  task automatic t_cascade(input logic [7:0] v);
    for (int k = 7; k >= 0; k--) begin
      logic old;
      old = m[7];
      ser_in = v[k]; #2 sclk = 1'b1; m = {m[14:0], v[k]};
      #2 chk("R7 hold while high", {15'h0, c0}, {15'h0, old});
      #3 sclk = 1'b0;
      #2 chk("R7 update on fall", {15'h0, c0}, {15'h0, m[7]});
      #1;
    end
  endtask

  task automatic t_tied(input logic [7:0] v);
    for (int k = 7; k >= 0; k--) begin
      ser_in = v[k]; #2 sclk = 1'b1; lclk = 1'b1; st = m; m = {m[14:0], v[k]};
      #3 sclk = 1'b0; lclk = 1'b0;
      #2 chk("R8 tied clocks one behind", {d1, d0}, st);
      #3;
    end
  endtask

  task automatic t_chain(input logic [15:0] v);
    for (int k = 15; k >= 0; k--) shift_bit(v[k]);
    latch();
    chk("R9 16-bit chain", {d1, d0}, v);
    chk("R9 chain cascade", {15'h0, c1}, {15'h0, v[15]});
  endtask

  task automatic t_mid_clear(input logic [15:0] v);
    for (int k = 0; k < 5; k++) shift_bit(1'b1);
    latch();
    #1 clr_n = 1'b0; #1;
    chk("R3 mid clear drives", {d1, d0}, 16'h0);
    chk("R3 mid clear cascades", {14'h0, c1, c0}, 16'h0);
    release_clear();
    latch();
    chk("R4 after mid clear", {d1, d0}, 16'h0);
    for (int k = 15; k >= 0; k--) shift_bit(v[k]);
    latch();
    chk("R9 transfer after clear", {d1, d0}, v);
  endtask

  initial begin
    t_reset();
    t_release();
    t_shift_load(8'hB4);
    t_enable();
    t_cascade(8'h0F);
    t_tied(8'h96);
    t_chain(16'hC3A9);
    t_enable();
    t_mid_clear(16'h5E17);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule